// File: doc/BRIEF.md
# Bridge Transaction Ordering Queue

This block is the per-direction transaction queue of an internal bus bridge. Its target side takes three kinds of traffic: write address beats, write data beats and read requests, plus read data completions travelling back. Its master side replays them under a fixed set of passing rules. The write address and the write data are caught in separate holding registers. They become one queue entry only once both have arrived. A write is retired from the queue only after its address has been issued and its data beat has been taken.

Issue order follows arrival order except where the rules require otherwise. A write or a completion may go ahead of a read request that is stalled at the front of the queue. A read request never goes ahead of anything. Writes never overtake writes, and completions never overtake writes or other completions. Each accepted read is given a tag that stays live until a retire pulse carrying that tag arrives. While strong ordering is enabled, an incoming write whose 64-byte line matches any live read is refused with a retry. A full queue or an exhausted tag pool also answers with retry instead of dropping the request.

Top module: `bridge_order_queue`

## Requirements
- R1: After reset the queue is empty: `m_valid`, `m_wd_valid` and all target ack/retry outputs are 0, and `t_wa_ready` and `t_wd_ready` are 1.
- R2: A write address and a write data beat are each captured when valid and ready are both high, and ready stays low while one is held. In the cycle after the later of the two is captured, exactly one of `t_wr_ack` or `t_wr_retry` is high. On that cycle both holders are released.
- R3: After a write address is issued, `m_wd_valid` stays high with stable data until `m_wd_ready`. Only then is the entry freed. Nothing else issues during this time.
- R4: Writes are issued in the order they were acknowledged.
- R5: When the oldest entry is a read request and `m_rd_ready` is low, the oldest write or completion in the queue is issued if its own ready is high.
- R6: A read request is issued only from the oldest position of the queue.
- R7: A completion is issued only when no older write or completion is queued. It may pass an older read request.
- R8: With strong ordering enabled, a write is refused with `t_wr_retry` while its address bits [ADDR_W-1:6] equal those of any accepted read whose tag has not been retired.
- R9: A `ret_valid` pulse frees its tag from the next cycle on, so a write to that line can then be acknowledged.
- R10: Requests are accepted in the order write, then read, then completion, each only if free slots remain. Free slots are counted from the occupancy at the start of the cycle. A request that finds no slot gets retry in the same cycle.
- R11: An accepted read takes the lowest-numbered free tag. With no free tag, the read gets `t_rd_retry`.
- R12: `m_kind` encodes 0 for a write address, 1 for a read request and 2 for a read completion. Read entries carry data 0, completion entries carry address 0, and write entries carry tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| t_wa_valid | input | 1 | Incoming write address valid |
| t_wa_addr | input | ADDR_W | Incoming write address |
| t_wa_ready | output | 1 | Write address holder empty |
| t_wd_valid | input | 1 | Incoming write data valid |
| t_wd_data | input | DATA_W | Incoming write data |
| t_wd_ready | output | 1 | Write data holder empty |
| t_wr_ack | output | 1 | Paired write accepted into the queue |
| t_wr_retry | output | 1 | Paired write refused, sender must retry |
| t_rd_valid | input | 1 | Incoming read request |
| t_rd_addr | input | ADDR_W | Read request address |
| t_rd_ack | output | 1 | Read accepted this cycle |
| t_rd_retry | output | 1 | Read refused this cycle |
| t_cpl_valid | input | 1 | Incoming read completion |
| t_cpl_tag | input | TAG_W | Completion tag |
| t_cpl_data | input | DATA_W | Completion data |
| t_cpl_ack | output | 1 | Completion accepted this cycle |
| t_cpl_retry | output | 1 | Completion refused this cycle |
| m_wr_ready | input | 1 | Master side can take a write address |
| m_rd_ready | input | 1 | Master side can take a read request |
| m_cpl_ready | input | 1 | Master side can take a completion |
| m_valid | output | 1 | An entry is issued this cycle |
| m_kind | output | 2 | Kind of the issued entry |
| m_addr | output | ADDR_W | Address of the issued entry |
| m_data | output | DATA_W | Data of the issued entry |
| m_tag | output | TAG_W | Tag of the issued entry |
| m_wd_valid | output | 1 | Write data beat pending on master side |
| m_wd_data | output | DATA_W | Write data beat |
| m_wd_ready | input | 1 | Master side took the write data beat |
| ret_valid | input | 1 | A read has been answered |
| ret_tag | input | TAG_W | Tag of the answered read |

## Verification
The embedded checks assume that `ret_valid` only names a tag that is live, meaning a read that has already left the queue and has not been retired yet. The bench keeps its own list of issued, unretired read tags and draws retire pulses only from that list. The bench also takes any master-side ready as a same-cycle handshake, which is what the assertions on the data phase expect. Address lines are drawn from a small set so that line conflicts, tag exhaustion and a full queue all occur often.

// File: rtl/bq_pkg.sv
// Shared definitions for the bridge ordering queue.
package bq_pkg;
    // Kind code of a queued transaction; values are visible on m_kind.
    typedef enum logic [1:0] {
        KIND_WR  = 2'd0,
        KIND_RD  = 2'd1,
        KIND_CPL = 2'd2
    } kind_e;
endpackage

// File: rtl/bq_write_pair.sv
// Holds a write address and a write data beat until both are present,
// then offers them as one pair for a single cycle.
// Assumes the consumer decides ack or retry in the cycle the pair is shown.
module bq_write_pair #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wa_valid_i,
    input  logic [ADDR_W-1:0] wa_addr_i,
    output logic              wa_ready_o,
    input  logic              wd_valid_i,
    input  logic [DATA_W-1:0] wd_data_i,
    output logic              wd_ready_o,
    output logic              pair_o,
    output logic [ADDR_W-1:0] pair_addr_o,
    output logic [DATA_W-1:0] pair_data_o
);
    logic              wa_held, wd_held;
    logic [ADDR_W-1:0] wa_addr_q;
    logic [DATA_W-1:0] wd_data_q;

    assign wa_ready_o  = !wa_held;
    assign wd_ready_o  = !wd_held;
    assign pair_o      = wa_held && wd_held;
    assign pair_addr_o = wa_addr_q;
    assign pair_data_o = wd_data_q;

    // Capture each half while empty; release both once the pair is decided.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wa_held   <= 1'b0;
            wd_held   <= 1'b0;
            wa_addr_q <= '0;
            wd_data_q <= '0;
        end else if (pair_o) begin
            wa_held <= 1'b0;
            wd_held <= 1'b0;
        end else begin
            if (wa_valid_i && !wa_held) begin
                wa_held   <= 1'b1;
                wa_addr_q <= wa_addr_i;
            end
            if (wd_valid_i && !wd_held) begin
                wd_held   <= 1'b1;
                wd_data_q <= wd_data_i;
            end
        end
    end

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_held && !pair_o) |=> (wa_held && $stable(wa_addr_q)));
    // R2
    pair_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_o |=> (wa_ready_o && wd_ready_o));
endmodule

// File: rtl/bq_read_tags.sv
// Table of live read tags with the line address each one covers.
// Hands out the lowest free tag, frees a tag on retire, and flags a write
// whose 64-byte line matches any live read when strong ordering is on.
// Assumes retire pulses only name live tags.
module bq_read_tags #(
    parameter int ADDR_W       = 32,
    parameter int TAG_W        = 3,
    parameter bit STRONG_ORDER = 1'b1,
    localparam int NTAG        = 1 << TAG_W,
    localparam int LINE_LSB    = 6,
    localparam int LINE_W      = ADDR_W - LINE_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic              conflict_o,
    output logic              alloc_ok_o,
    output logic [TAG_W-1:0]  alloc_tag_o,
    input  logic              take_i,
    input  logic [ADDR_W-1:0] take_addr_i,
    input  logic              ret_valid_i,
    input  logic [TAG_W-1:0]  ret_tag_i
);
    logic [NTAG-1:0]   busy_q, busy_n;
    logic [LINE_W-1:0] line_q [NTAG];

    // Lowest free tag.
    always_comb begin
        alloc_ok_o  = 1'b0;
        alloc_tag_o = '0;
        for (int t = 0; t < NTAG; t++) begin
            if (!busy_q[t] && !alloc_ok_o) begin
                alloc_ok_o  = 1'b1;
                alloc_tag_o = TAG_W'(t);
            end
        end
    end

    // Line conflict against every live read, only when strong ordering is built in.
    generate
        if (STRONG_ORDER) begin : g_strong
            always_comb begin
                conflict_o = 1'b0;
                for (int t = 0; t < NTAG; t++) begin
                    if (busy_q[t] && line_q[t] == wr_addr_i[ADDR_W-1:LINE_LSB])
                        conflict_o = 1'b1;
                end
            end
        end else begin : g_relaxed
            assign conflict_o = 1'b0;
        end
    endgenerate

    // Next live set: new read sets its tag, retire clears its tag.
    always_comb begin
        busy_n = busy_q;
        if (take_i)      busy_n[alloc_tag_o] = 1'b1;
        if (ret_valid_i) busy_n[ret_tag_i]   = 1'b0;
    end

    // Register the live set.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_n;
    end

    // Record the line of each newly taken tag.
    always_ff @(posedge clk) begin
        if (take_i) line_q[alloc_tag_o] <= take_addr_i[ADDR_W-1:LINE_LSB];
    end

    // R9
    retire_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid_i |-> busy_q[ret_tag_i]);
    // R11
    alloc_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> busy_q[$past(alloc_tag_o)]);
endmodule

// File: rtl/bq_entry_store.sv
// Age-ordered entry array: position 0 is the oldest, removal closes the gap.
// Selects at most one entry per cycle under the passing rules and runs the
// two-step write issue (address, then data beat).
// Assumes the caller never pushes beyond the free slots at cycle start.
module bq_entry_store
    import bq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 3,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_wr_i,
    input  logic [ADDR_W-1:0] push_wr_addr_i,
    input  logic [DATA_W-1:0] push_wr_data_i,
    input  logic              push_rd_i,
    input  logic [ADDR_W-1:0] push_rd_addr_i,
    input  logic [TAG_W-1:0]  push_rd_tag_i,
    input  logic              push_cpl_i,
    input  logic [DATA_W-1:0] push_cpl_data_i,
    input  logic [TAG_W-1:0]  push_cpl_tag_i,
    input  logic              wr_ready_i,
    input  logic              rd_ready_i,
    input  logic              cpl_ready_i,
    input  logic              wd_ready_i,
    output logic [CW-1:0]     count_o,
    output logic              m_valid_o,
    output kind_e             m_kind_o,
    output logic [ADDR_W-1:0] m_addr_o,
    output logic [DATA_W-1:0] m_data_o,
    output logic [TAG_W-1:0]  m_tag_o,
    output logic              wd_valid_o,
    output logic [DATA_W-1:0] wd_data_o
);
    kind_e             q_kind [DEPTH];
    logic [ADDR_W-1:0] q_addr [DEPTH];
    logic [DATA_W-1:0] q_data [DEPTH];
    logic [TAG_W-1:0]  q_tag  [DEPTH];
    kind_e             n_kind [DEPTH];
    logic [ADDR_W-1:0] n_addr [DEPTH];
    logic [DATA_W-1:0] n_data [DEPTH];
    logic [TAG_W-1:0]  n_tag  [DEPTH];
    logic [CW-1:0]     cnt, n_cnt;
    logic              wphase;
    logic [IW-1:0]     widx;
    logic              first_found, sel_ok, rm_en;
    logic [IW-1:0]     first_idx, sel, rm_idx;

    // Pick the issue candidate: a read only at the head, else the oldest non-read.
    always_comb begin
        first_found = 1'b0;
        first_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < cnt && q_kind[i] != KIND_RD && !first_found) begin
                first_found = 1'b1;
                first_idx   = IW'(i);
            end
        end
        sel_ok = 1'b0;
        sel    = '0;
        if (!wphase && cnt != '0) begin
            if (q_kind[0] == KIND_RD && rd_ready_i) begin
                sel_ok = 1'b1;
            end else if (first_found &&
                         ((q_kind[first_idx] == KIND_WR  && wr_ready_i) ||
                          (q_kind[first_idx] == KIND_CPL && cpl_ready_i))) begin
                sel_ok = 1'b1;
                sel    = first_idx;
            end
        end
    end

    assign m_valid_o  = sel_ok;
    assign m_kind_o   = q_kind[sel];
    assign m_addr_o   = q_addr[sel];
    assign m_data_o   = q_data[sel];
    assign m_tag_o    = q_tag[sel];
    assign wd_valid_o = wphase;
    assign wd_data_o  = q_data[widx];
    assign count_o    = cnt;

    // Next array: close the gap of a removed entry, then append new entries.
    always_comb begin
        n_kind = q_kind;
        n_addr = q_addr;
        n_data = q_data;
        n_tag  = q_tag;
        n_cnt  = cnt;
        rm_en  = (sel_ok && q_kind[sel] != KIND_WR) || (wphase && wd_ready_i);
        rm_idx = wphase ? widx : sel;
        if (rm_en) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IW'(i) >= rm_idx) begin
                    n_kind[i] = q_kind[i+1];
                    n_addr[i] = q_addr[i+1];
                    n_data[i] = q_data[i+1];
                    n_tag[i]  = q_tag[i+1];
                end
            end
            n_cnt = cnt - 1'b1;
        end
        if (push_wr_i && n_cnt < CW'(DEPTH)) begin
            n_kind[n_cnt[IW-1:0]] = KIND_WR;
            n_addr[n_cnt[IW-1:0]] = push_wr_addr_i;
            n_data[n_cnt[IW-1:0]] = push_wr_data_i;
            n_tag[n_cnt[IW-1:0]]  = '0;
            n_cnt = n_cnt + 1'b1;
        end
        if (push_rd_i && n_cnt < CW'(DEPTH)) begin
            n_kind[n_cnt[IW-1:0]] = KIND_RD;
            n_addr[n_cnt[IW-1:0]] = push_rd_addr_i;
            n_data[n_cnt[IW-1:0]] = '0;
            n_tag[n_cnt[IW-1:0]]  = push_rd_tag_i;
            n_cnt = n_cnt + 1'b1;
        end
        if (push_cpl_i && n_cnt < CW'(DEPTH)) begin
            n_kind[n_cnt[IW-1:0]] = KIND_CPL;
            n_addr[n_cnt[IW-1:0]] = '0;
            n_data[n_cnt[IW-1:0]] = push_cpl_data_i;
            n_tag[n_cnt[IW-1:0]]  = push_cpl_tag_i;
            n_cnt = n_cnt + 1'b1;
        end
    end

    // Occupancy and write data phase control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            wphase <= 1'b0;
            widx   <= '0;
        end else begin
            cnt <= n_cnt;
            if (sel_ok && q_kind[sel] == KIND_WR) begin
                wphase <= 1'b1;
                widx   <= sel;
            end else if (wphase && wd_ready_i) begin
                wphase <= 1'b0;
            end
        end
    end

    // Entry payload storage.
    always_ff @(posedge clk) begin
        q_kind <= n_kind;
        q_addr <= n_addr;
        q_data <= n_data;
        q_tag  <= n_tag;
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    // R3
    addr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid_o && m_kind_o == KIND_WR) |=> wd_valid_o);
    // R3
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_valid_o && !wd_ready_i) |=> (wd_valid_o && $stable(wd_data_o)));
    // R3
    quiet_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_valid_o |-> !m_valid_o);
    // R6
    rd_from_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid_o && m_kind_o == KIND_RD) |-> (q_kind[0] == KIND_RD && rd_ready_i));
endmodule

// File: rtl/bridge_order_queue.sv
// One-direction ordering queue of a bus bridge. Pairs write address and data,
// admits writes, reads and completions in that priority, refuses with retry
// on a full queue, no read tag, or a write hitting a live read line, and
// issues entries under the passing rules.
// Assumes a master-side ready means the issued item is taken in that cycle.
module bridge_order_queue
    import bq_pkg::*;
#(
    parameter int DEPTH        = 8,
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 32,
    parameter int TAG_W        = 3,
    parameter bit STRONG_ORDER = 1'b1,
    localparam int CW          = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              t_wa_valid,
    input  logic [ADDR_W-1:0] t_wa_addr,
    output logic              t_wa_ready,
    input  logic              t_wd_valid,
    input  logic [DATA_W-1:0] t_wd_data,
    output logic              t_wd_ready,
    output logic              t_wr_ack,
    output logic              t_wr_retry,
    input  logic              t_rd_valid,
    input  logic [ADDR_W-1:0] t_rd_addr,
    output logic              t_rd_ack,
    output logic              t_rd_retry,
    input  logic              t_cpl_valid,
    input  logic [TAG_W-1:0]  t_cpl_tag,
    input  logic [DATA_W-1:0] t_cpl_data,
    output logic              t_cpl_ack,
    output logic              t_cpl_retry,
    input  logic              m_wr_ready,
    input  logic              m_rd_ready,
    input  logic              m_cpl_ready,
    output logic              m_valid,
    output logic [1:0]        m_kind,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_data,
    output logic [TAG_W-1:0]  m_tag,
    output logic              m_wd_valid,
    output logic [DATA_W-1:0] m_wd_data,
    input  logic              m_wd_ready,
    input  logic              ret_valid,
    input  logic [TAG_W-1:0]  ret_tag
);
    logic              pair;
    logic [ADDR_W-1:0] pair_addr;
    logic [DATA_W-1:0] pair_data;
    logic              conflict, alloc_ok;
    logic [TAG_W-1:0]  alloc_tag;
    logic [CW-1:0]     occ, room;
    logic              wr_ok, rd_ok, cpl_ok;
    kind_e             kind_out;

    bq_write_pair #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pair (
        .clk(clk), .rst_n(rst_n),
        .wa_valid_i(t_wa_valid), .wa_addr_i(t_wa_addr), .wa_ready_o(t_wa_ready),
        .wd_valid_i(t_wd_valid), .wd_data_i(t_wd_data), .wd_ready_o(t_wd_ready),
        .pair_o(pair), .pair_addr_o(pair_addr), .pair_data_o(pair_data)
    );

    bq_read_tags #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .STRONG_ORDER(STRONG_ORDER)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .wr_addr_i(pair_addr), .conflict_o(conflict),
        .alloc_ok_o(alloc_ok), .alloc_tag_o(alloc_tag),
        .take_i(rd_ok), .take_addr_i(t_rd_addr),
        .ret_valid_i(ret_valid), .ret_tag_i(ret_tag)
    );

    // Admission: write first, then read, then completion, against start-of-cycle room.
    always_comb begin
        room   = CW'(DEPTH) - occ;
        wr_ok  = pair && (room != '0) && !conflict;
        rd_ok  = t_rd_valid && alloc_ok && (room > CW'(wr_ok));
        cpl_ok = t_cpl_valid && (room > (CW'(wr_ok) + CW'(rd_ok)));
    end

    assign t_wr_ack    = wr_ok;
    assign t_wr_retry  = pair && !wr_ok;
    assign t_rd_ack    = rd_ok;
    assign t_rd_retry  = t_rd_valid && !rd_ok;
    assign t_cpl_ack   = cpl_ok;
    assign t_cpl_retry = t_cpl_valid && !cpl_ok;

    bq_entry_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push_wr_i(wr_ok), .push_wr_addr_i(pair_addr), .push_wr_data_i(pair_data),
        .push_rd_i(rd_ok), .push_rd_addr_i(t_rd_addr), .push_rd_tag_i(alloc_tag),
        .push_cpl_i(cpl_ok), .push_cpl_data_i(t_cpl_data), .push_cpl_tag_i(t_cpl_tag),
        .wr_ready_i(m_wr_ready), .rd_ready_i(m_rd_ready), .cpl_ready_i(m_cpl_ready),
        .wd_ready_i(m_wd_ready), .count_o(occ),
        .m_valid_o(m_valid), .m_kind_o(kind_out), .m_addr_o(m_addr),
        .m_data_o(m_data), .m_tag_o(m_tag),
        .wd_valid_o(m_wd_valid), .wd_data_o(m_wd_data)
    );

    assign m_kind = kind_out;

    // R2
    wr_answer_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(t_wr_ack && t_wr_retry));
    // R8
    conflict_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair && conflict) |-> t_wr_retry);
endmodule

// File: tb/bridge_order_queue_test.sv
`timescale 1ns/1ps
module bridge_order_queue_test;
    localparam int DEPTH = 8;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int TW    = 3;
    localparam int NT    = 8;
    localparam int CYCLES = 15000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic t_wa_valid = 0, t_wd_valid = 0, t_rd_valid = 0, t_cpl_valid = 0;
    logic [AW-1:0] t_wa_addr = '0, t_rd_addr = '0;
    logic [DW-1:0] t_wd_data = '0, t_cpl_data = '0;
    logic [TW-1:0] t_cpl_tag = '0, ret_tag = '0;
    logic m_wr_ready = 0, m_rd_ready = 0, m_cpl_ready = 0, m_wd_ready = 0, ret_valid = 0;
    logic t_wa_ready, t_wd_ready, t_wr_ack, t_wr_retry, t_rd_ack, t_rd_retry;
    logic t_cpl_ack, t_cpl_retry, m_valid, m_wd_valid;
    logic [1:0] m_kind;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_data, m_wd_data;
    logic [TW-1:0] m_tag;

    bridge_order_queue uut (
        .clk(clk), .rst_n(rst_n),
        .t_wa_valid(t_wa_valid), .t_wa_addr(t_wa_addr), .t_wa_ready(t_wa_ready),
        .t_wd_valid(t_wd_valid), .t_wd_data(t_wd_data), .t_wd_ready(t_wd_ready),
        .t_wr_ack(t_wr_ack), .t_wr_retry(t_wr_retry),
        .t_rd_valid(t_rd_valid), .t_rd_addr(t_rd_addr), .t_rd_ack(t_rd_ack), .t_rd_retry(t_rd_retry),
        .t_cpl_valid(t_cpl_valid), .t_cpl_tag(t_cpl_tag), .t_cpl_data(t_cpl_data),
        .t_cpl_ack(t_cpl_ack), .t_cpl_retry(t_cpl_retry),
        .m_wr_ready(m_wr_ready), .m_rd_ready(m_rd_ready), .m_cpl_ready(m_cpl_ready),
        .m_valid(m_valid), .m_kind(m_kind), .m_addr(m_addr), .m_data(m_data), .m_tag(m_tag),
        .m_wd_valid(m_wd_valid), .m_wd_data(m_wd_data), .m_wd_ready(m_wd_ready),
        .ret_valid(ret_valid), .ret_tag(ret_tag)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    function automatic void chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endfunction

    // Behavioural reference state.
    typedef struct {
        int            kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        int            tag;
    } ent_t;
    ent_t          mq[$];
    int            issued[$];
    bit            wa_h = 0, wd_h = 0, wph = 0;
    logic [AW-1:0] wa_a = '0;
    logic [DW-1:0] wd_d = '0;
    int            widx = 0;
    bit            busy [NT];
    logic [AW-7:0] lines [NT];
    logic [AW-7:0] last_conf_line = '0;
    bit            conf_seen = 0;
    int ev_wpass = 0, ev_cpass = 0, ev_conf = 0, ev_reacc = 0;
    int ev_full = 0, ev_notag = 0, ev_wr_issued = 0;

    task automatic drive(int phase);
        int lr;
        lr = (phase == 4) ? 1 : 15;
        t_wa_valid  = ($urandom_range(0, 2) != 0);
        t_wa_addr   = {$urandom_range(0, 1) == 0 ? 26'd0 : 26'd0, 6'd0} |
                      (AW'($urandom_range(0, lr)) << 6) | AW'($urandom_range(0, 63));
        t_wd_valid  = ($urandom_range(0, 2) != 0);
        t_wd_data   = $urandom;
        t_rd_valid  = (phase == 3) ? ($urandom_range(0, 1) == 0) : ($urandom_range(0, 3) == 0);
        t_rd_addr   = (AW'($urandom_range(0, lr)) << 6) | AW'($urandom_range(0, 63));
        t_cpl_valid = ($urandom_range(0, 3) == 0);
        t_cpl_data  = $urandom;
        t_cpl_tag   = TW'($urandom_range(0, NT - 1));
        case (phase)
            1: begin m_rd_ready = ($urandom_range(0, 9) == 0); m_wr_ready = 1; m_cpl_ready = 1; end
            2: begin m_rd_ready = 0; m_wr_ready = ($urandom_range(0, 9) == 0); m_cpl_ready = 0; end
            default: begin
                m_rd_ready  = ($urandom_range(0, 1) == 0);
                m_wr_ready  = ($urandom_range(0, 1) == 0);
                m_cpl_ready = ($urandom_range(0, 1) == 0);
            end
        endcase
        m_wd_ready = ($urandom_range(0, 2) != 0);
        ret_valid  = 0;
        if (issued.size() > 0 && $urandom_range(0, (phase == 3) ? 15 : 3) == 0) begin
            ret_valid = 1;
            ret_tag   = TW'(issued[$urandom_range(0, issued.size() - 1)]);
        end
    endtask

    // Compare every output against the reference, then advance the reference.
    task automatic eval_cycle();
        bit e_wr_ack, e_wr_retry, e_rd_ack, e_cpl_ack, conf, decide;
        int free, alloc, es, f;
        decide = wa_h && wd_h;
        free = DEPTH - mq.size();
        conf = 0;
        for (int t = 0; t < NT; t++) if (busy[t] && lines[t] == wa_a[AW-1:6]) conf = 1;
        e_wr_ack   = decide && free >= 1 && !conf;
        e_wr_retry = decide && !e_wr_ack;
        alloc = -1;
        for (int t = NT - 1; t >= 0; t--) if (!busy[t]) alloc = t;
        e_rd_ack  = t_rd_valid && alloc >= 0 && free >= 1 + int'(e_wr_ack);
        e_cpl_ack = t_cpl_valid && free >= 1 + int'(e_wr_ack) + int'(e_rd_ack);
        es = -1;
        if (!wph && mq.size() > 0) begin
            if (mq[0].kind == 1 && m_rd_ready) es = 0;
            else begin
                f = -1;
                for (int i = mq.size() - 1; i >= 0; i--) if (mq[i].kind != 1) f = i;
                if (f >= 0 && ((mq[f].kind == 0 && m_wr_ready) || (mq[f].kind == 2 && m_cpl_ready)))
                    es = f;
            end
        end

        chk("R2", "t_wa_ready", t_wa_ready, !wa_h);
        chk("R2", "t_wd_ready", t_wd_ready, !wd_h);
        chk("R2", "t_wr_ack", t_wr_ack, e_wr_ack);
        chk("R8", "t_wr_retry", t_wr_retry, e_wr_retry);
        chk("R11", "t_rd_ack", t_rd_ack, e_rd_ack);
        chk("R10", "t_rd_retry", t_rd_retry, t_rd_valid && !e_rd_ack);
        chk("R10", "t_cpl_ack", t_cpl_ack, e_cpl_ack);
        chk("R10", "t_cpl_retry", t_cpl_retry, t_cpl_valid && !e_cpl_ack);
        chk("R5 R6 R7", "m_valid", m_valid, es >= 0);
        chk("R3", "m_wd_valid", m_wd_valid, wph);
        if (es >= 0) begin
            chk("R12", "m_kind", m_kind, mq[es].kind);
            chk("R4", "m_addr", m_addr, mq[es].addr);
            chk("R7", "m_data", m_data, mq[es].data);
            chk("R11", "m_tag", m_tag, mq[es].tag);
        end
        if (wph) chk("R3", "m_wd_data", m_wd_data, mq[widx].data);

        if (es > 0 && mq[0].kind == 1 && mq[es].kind == 0) ev_wpass++;
        if (es > 0 && mq[0].kind == 1 && mq[es].kind == 2) ev_cpass++;
        if (decide && conf) begin ev_conf++; conf_seen = 1; last_conf_line = wa_a[AW-1:6]; end
        if (e_wr_ack && conf_seen && wa_a[AW-1:6] == last_conf_line) ev_reacc++;
        if ((decide && free == 0) || (t_cpl_valid && !e_cpl_ack)) ev_full++;
        if (t_rd_valid && alloc < 0) ev_notag++;

        if (es >= 0) begin
            if (mq[es].kind == 0) begin
                wph = 1; widx = es; ev_wr_issued++;
            end else begin
                if (mq[es].kind == 1) issued.push_back(mq[es].tag);
                mq.delete(es);
            end
        end else if (wph && m_wd_ready) begin
            mq.delete(widx);
            wph = 0;
        end
        if (e_wr_ack) mq.push_back('{kind: 0, addr: wa_a, data: wd_d, tag: 0});
        if (e_rd_ack) begin
            mq.push_back('{kind: 1, addr: t_rd_addr, data: '0, tag: alloc});
            busy[alloc] = 1;
            lines[alloc] = t_rd_addr[AW-1:6];
        end
        if (e_cpl_ack) mq.push_back('{kind: 2, addr: '0, data: t_cpl_data, tag: int'(t_cpl_tag)});
        if (ret_valid) begin
            busy[ret_tag] = 0;
            for (int i = 0; i < issued.size(); i++)
                if (issued[i] == int'(ret_tag)) begin issued.delete(i); break; end
        end
        if (decide) begin
            wa_h = 0; wd_h = 0;
        end else begin
            if (t_wa_valid && !wa_h) begin wa_h = 1; wa_a = t_wa_addr; end
            if (t_wd_valid && !wd_h) begin wd_h = 1; wd_d = t_wd_data; end
        end
    endtask

    initial begin
        for (int t = 0; t < NT; t++) begin busy[t] = 0; lines[t] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "m_valid", m_valid, 0);
        chk("R1", "m_wd_valid", m_wd_valid, 0);
        chk("R1", "t_wa_ready", t_wa_ready, 1);
        chk("R1", "t_wd_ready", t_wd_ready, 1);
        chk("R1", "t_wr_ack", t_wr_ack, 0);
        chk("R1", "t_rd_ack", t_rd_ack, 0);
        chk("R1", "t_cpl_ack", t_cpl_ack, 0);
        for (int cyc = 0; cyc < CYCLES; cyc++) begin
            @(negedge clk);
            drive((cyc / 1000) % 5);
            #1;
            eval_cycle();
        end
        chk("R4", "writes issued", ev_wr_issued > 0, 1);
        chk("R5", "write passed stalled read", ev_wpass > 0, 1);
        chk("R7", "completion passed stalled read", ev_cpass > 0, 1);
        chk("R8", "line conflicts refused", ev_conf > 0, 1);
        chk("R9", "line accepted after retire", ev_reacc > 0, 1);
        chk("R10", "full queue retries", ev_full > 0, 1);
        chk("R11", "tag pool exhausted", ev_notag > 0, 1);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog: run did not finish actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule